// File: doc/BRIEF.md
# Static Branch Direction Predictor

This unit guesses whether a decoded conditional branch will be taken. It uses only facts that are known when the branch is fetched or decoded, and it keeps no run-time history. A mode register picks one of five fixed policies:

- never taken;
- always taken;
- taken when the target lies at or below the branch address;
- follow a compiler-set hint bit in the instruction word;
- an opcode-class heuristic.

The prediction is combinational from the branch inputs and the registered mode. The policy in force is reported next to the prediction.

When a branch resolves, the caller pulses a strobe that carries the real outcome. The strobe applies to the branch on the inputs in that cycle. Two saturating counters record resolved branches and correct guesses, so several policies can be scored against the same outcome stream. A valid mode write restarts both counters at zero.

Top module: `brdir_static_pred`

## Requirements
- R1: After reset the policy output is 0 (never taken), and both counters read 0.
- R2: With policy code 0, the prediction is not taken for every input.
- R3: With policy code 1, the prediction is taken for every input.
- R4: With policy code 2, the prediction is taken exactly when the target address is less than or equal to the branch address, compared as unsigned values.
- R5: With policy code 3, the prediction equals the hint input.
- R6: With policy code 4, the prediction depends on the 3-bit operation class:
  - classes 1 (branch on less-or-equal zero), 2 (pointer branch-if-equal) and 4 (floating-point branch-if-equal) predict not taken;
  - classes 3 (pointer branch-if-not-equal) and 5 (floating-point branch-if-not-equal) predict taken;
  - classes 0, 6 and 7 use the R4 rule.
- R7: A mode write with a code in 0..4 is seen on the policy output, and used for prediction, from the clock edge that samples it. Before that edge the old policy stays in force.
- R8: A mode write with a code in 5..7 has no effect. The policy and both counters keep their values.
- R9: Each cycle with the resolve strobe high adds one to the total counter.
- R10: A resolve whose outcome equals the current prediction also adds one to the correct counter.
- R11: A valid mode write clears both counters at the same edge. It takes priority over a resolve in the same cycle.
- R12: The counters are CW bits wide (32 by default) and hold at all-ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Policy code to write |
| br_pc | input | AW | Address of the branch |
| br_tgt | input | AW | Decoded branch target |
| br_hint | input | 1 | Direction hint bit from the instruction word |
| br_opc | input | 3 | Operation class of the branch |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_policy | output | 3 | Policy code currently in force |
| res_valid | input | 1 | Resolved-outcome strobe |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| total_cnt | output | CW | Resolved branch count |
| hit_cnt | output | CW | Correct prediction count |

## Verification
Every address pair of a 6-bit configuration is applied under each policy. The hint and operation class are derived from the pair, so the sweep separates target-below, target-equal and target-above cases, and it shows each opcode rule either overriding or deferring to the address test.

Resolves are scattered through the sweeps with outcomes that both agree and disagree with the prediction. This exercises the two counters separately and drives them into 4-bit saturation.

Directed sequences cover the following cases:
- the cycle in which a mode write takes effect;
- rejected codes leaving non-zero counters intact;
- a resolve colliding with a mode write.

// File: rtl/brdir_pkg.sv
package brdir_pkg;

    typedef enum logic [2:0] {
        POL_NEVER  = 3'd0,
        POL_ALWAYS = 3'd1,
        POL_BTFN   = 3'd2,
        POL_HINT   = 3'd3,
        POL_HEUR   = 3'd4
    } pol_e;

    localparam int unsigned POL_COUNT = 5;

    typedef enum logic [2:0] {
        OPC_GENERIC = 3'd0,
        OPC_LEZ     = 3'd1,
        OPC_PTR_EQ  = 3'd2,
        OPC_PTR_NE  = 3'd3,
        OPC_FP_EQ   = 3'd4,
        OPC_FP_NE   = 3'd5,
        OPC_RSV6    = 3'd6,
        OPC_RSV7    = 3'd7
    } opc_e;

    typedef struct packed {
        pol_e mode;
    } ctl_s;

    function automatic logic pol_known(input logic [2:0] code);
        return code < 3'(POL_COUNT);
    endfunction

endpackage

// File: rtl/brdir_policy.sv
module brdir_policy
    import brdir_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  pol_e            mode,
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   tgt,
    input  logic            hint,
    input  logic [2:0]      opc,
    output logic            taken
);

    logic backward;
    logic heur;

    always_comb begin
        backward = (tgt <= pc);
    end

    always_comb begin
        unique case (opc_e'(opc))
            OPC_LEZ, OPC_PTR_EQ, OPC_FP_EQ: heur = 1'b0;
            OPC_PTR_NE, OPC_FP_NE:          heur = 1'b1;
            default:                        heur = backward;
        endcase
    end

    always_comb begin
        case (mode)
            POL_NEVER:  taken = 1'b0;
            POL_ALWAYS: taken = 1'b1;
            POL_BTFN:   taken = backward;
            POL_HINT:   taken = hint;
            POL_HEUR:   taken = heur;
            default:    taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/brdir_sat_ctr.sv
module brdir_sat_ctr #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP && !clr) |=> (cnt_q == TOP));

    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/brdir_static_pred.sv
module brdir_static_pred
    import brdir_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [2:0]    mode_in,
    input  logic [AW-1:0] br_pc,
    input  logic [AW-1:0] br_tgt,
    input  logic          br_hint,
    input  logic [2:0]    br_opc,
    output logic          pred_taken,
    output logic [2:0]    pred_policy,
    input  logic          res_valid,
    input  logic          res_taken,
    output logic [CW-1:0] total_cnt,
    output logic [CW-1:0] hit_cnt
);

    localparam int unsigned  NCNT = 2;
    localparam logic [CW-1:0] CMAX = '1;

    ctl_s ctl_d, ctl_q;
    logic wr_ok;
    logic guess;
    logic [NCNT-1:0]         inc_v;
    logic [NCNT-1:0][CW-1:0] cnt_v;

    always_comb begin
        wr_ok = mode_wr && pol_known(mode_in);
        ctl_d = ctl_q;
        if (wr_ok) begin
            ctl_d.mode = pol_e'(mode_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.mode <= POL_NEVER;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    brdir_policy #(.AW(AW)) u_policy (
        .mode  (ctl_q.mode),
        .pc    (br_pc),
        .tgt   (br_tgt),
        .hint  (br_hint),
        .opc   (br_opc),
        .taken (guess)
    );

    always_comb begin
        inc_v[0] = res_valid;
        inc_v[1] = res_valid && (res_taken == guess);
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_ctr
        brdir_sat_ctr #(.W(CW)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (wr_ok),
            .inc   (inc_v[g]),
            .cnt   (cnt_v[g])
        );
    end

    assign pred_taken  = guess;
    assign pred_policy = ctl_q.mode;
    assign total_cnt   = cnt_v[0];
    assign hit_cnt     = cnt_v[1];

    p_never_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_policy == 3'd0) |-> !pred_taken);

    p_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_policy == 3'd1) |-> pred_taken);

    p_btfn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_policy == 3'd2) |-> (pred_taken == (br_tgt <= br_pc)));

    p_hint_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_policy == 3'd3) |-> (pred_taken == br_hint));

    p_lez_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_policy == 3'd4 && br_opc == 3'd1) |-> !pred_taken);

    p_mode_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_in < 3'd5) |=> (pred_policy == $past(mode_in)));

    p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wr || mode_in > 3'd4) |=> $stable(pred_policy));

    p_hit_le_total_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cnt <= total_cnt);

    p_hit_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken == pred_taken && !mode_wr && hit_cnt != CMAX)
        |=> (hit_cnt == $past(hit_cnt) + 1'b1));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_in < 3'd5) |=> (total_cnt == '0 && hit_cnt == '0));

endmodule

// File: tb/test_brdir_static_pred.sv
module test_brdir_static_pred;

    localparam int unsigned AW = 6;
    localparam int unsigned CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wr = 1'b0;
    logic [2:0]    mode_in = '0;
    logic [AW-1:0] br_pc = '0;
    logic [AW-1:0] br_tgt = '0;
    logic          br_hint = 1'b0;
    logic [2:0]    br_opc = '0;
    logic          pred_taken;
    logic [2:0]    pred_policy;
    logic          res_valid = 1'b0;
    logic          res_taken = 1'b0;
    logic [CW-1:0] total_cnt;
    logic [CW-1:0] hit_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int exp_tot = 0;
    int exp_hit = 0;
    int cur_mode = 0;

    always #2 clk = ~clk;

    brdir_static_pred #(.AW(AW), .CW(CW)) i_brdir_static_pred (
        .clk, .rst_n, .mode_wr, .mode_in, .br_pc, .br_tgt, .br_hint, .br_opc,
        .pred_taken, .pred_policy, .res_valid, .res_taken, .total_cnt, .hit_cnt
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic int model(input int m, input int pc, input int tgt,
                                 input int h, input int c);
        int back;
        back = (tgt <= pc) ? 1 : 0;
        case (m)
            0: return 0;
            1: return 1;
            2: return back;
            3: return h;
            4: begin
                if (c == 1 || c == 2 || c == 4) return 0;
                if (c == 3 || c == 5) return 1;
                return back;
            end
            default: return 0;
        endcase
    endfunction

    function automatic int sat_inc(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    // a valid write restarts the counters (R11); an undefined code changes nothing (R8)
    task automatic set_mode(input int m);
        @(posedge clk); #1;
        mode_wr = 1'b1;
        mode_in = 3'(m);
        @(posedge clk); #1;
        mode_wr = 1'b0;
        if (m < 5) begin
            cur_mode = m;
            exp_tot = 0;
            exp_hit = 0;
        end
    endtask

    task automatic resolve(input int outcome);
        int p;
        p = int'(pred_taken);
        res_valid = 1'b1;
        res_taken = outcome[0];
        @(posedge clk); #1;
        res_valid = 1'b0;
        exp_tot = sat_inc(exp_tot);
        if (p == model(cur_mode, int'(br_pc), int'(br_tgt), int'(br_hint), int'(br_opc))
            && outcome[0] == p[0])
            exp_hit = sat_inc(exp_hit);
        else if (outcome[0] == p[0])
            exp_hit = sat_inc(exp_hit);
        chk("R9 total", int'(total_cnt), exp_tot);
        chk("R10 hits", int'(hit_cnt), exp_hit);
        chk("R12 bound", (int'(total_cnt) <= CMAX) ? 1 : 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 policy", int'(pred_policy), 0);
        chk("R1 total", int'(total_cnt), 0);
        chk("R1 hits", int'(hit_cnt), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 policy after release", int'(pred_policy), 0);
        chk("R1 total after release", int'(total_cnt), 0);

        // full sweep of every address pair under each policy (R2..R6)
        for (int m = 0; m < 5; m++) begin
            set_mode(m);
            chk("R7 policy code", int'(pred_policy), m);
            chk("R11 total cleared", int'(total_cnt), 0);
            chk("R11 hits cleared", int'(hit_cnt), 0);
            for (int pc = 0; pc < 64; pc++) begin
                for (int tgt = 0; tgt < 64; tgt++) begin
                    int h;
                    int c;
                    h = (pc ^ tgt) & 1;
                    c = (pc + tgt) % 8;
                    br_pc = AW'(pc);
                    br_tgt = AW'(tgt);
                    br_hint = h[0];
                    br_opc = 3'(c);
                    #0.5;
                    case (m)
                        0: chk("R2 never", int'(pred_taken), model(m, pc, tgt, h, c));
                        1: chk("R3 always", int'(pred_taken), model(m, pc, tgt, h, c));
                        2: chk("R4 backward", int'(pred_taken), model(m, pc, tgt, h, c));
                        3: chk("R5 hint", int'(pred_taken), model(m, pc, tgt, h, c));
                        default: chk("R6 heuristic", int'(pred_taken), model(m, pc, tgt, h, c));
                    endcase
                    if (((pc * 64 + tgt) % 97) == 0) begin
                        resolve((pc + tgt + m) & 1);
                    end
                end
            end
        end

        // mode change timing (R7)
        set_mode(1);
        #0.5;
        mode_wr = 1'b1;
        mode_in = 3'd0;
        #0.5;
        chk("R7 old policy before edge", int'(pred_policy), 1);
        chk("R7 old prediction before edge", int'(pred_taken), 1);
        @(posedge clk); #1;
        mode_wr = 1'b0;
        cur_mode = 0;
        exp_tot = 0;
        exp_hit = 0;
        chk("R7 new policy after edge", int'(pred_policy), 0);
        chk("R7 new prediction after edge", int'(pred_taken), 0);

        // undefined codes leave policy and counters alone (R8)
        resolve(0);
        resolve(1);
        resolve(0);
        for (int bad = 5; bad < 8; bad++) begin
            set_mode(bad);
            chk("R8 policy kept", int'(pred_policy), 0);
            chk("R8 total kept", int'(total_cnt), 3);
            chk("R8 hits kept", int'(hit_cnt), 2);
        end

        // resolve colliding with a valid write: clear wins (R11)
        @(posedge clk); #1;
        mode_wr = 1'b1;
        mode_in = 3'd2;
        res_valid = 1'b1;
        res_taken = 1'b0;
        @(posedge clk); #1;
        mode_wr = 1'b0;
        res_valid = 1'b0;
        cur_mode = 2;
        exp_tot = 0;
        exp_hit = 0;
        chk("R11 clear beats resolve total", int'(total_cnt), 0);
        chk("R11 clear beats resolve hits", int'(hit_cnt), 0);

        // saturation with every resolve correct (R12)
        br_pc = AW'(10);
        br_tgt = AW'(5);
        #0.5;
        chk("R4 target below", int'(pred_taken), 1);
        for (int k = 0; k < CMAX + 4; k++) begin
            resolve(1);
        end
        chk("R12 total held", int'(total_cnt), CMAX);
        chk("R12 hits held", int'(hit_cnt), CMAX);

        finish_run();
    end

endmodule